// File: doc/BRIEF.md
# Rational resize phase sequencer

This block turns a reduced scaling ratio for a single image axis, given as an output-count numerator and a source-count denominator, into the per-phase coefficient table a resampling stage walks through. One table entry is produced for each output phase, so the table has exactly `num` entries. Each entry carries a bilinear weight (512 selects the nearer source pixel entirely, 0 selects the next one), a count of source pixels to advance after this phase, a marker on the first entry, and a flag that says the table was built for a shrinking ratio.

A one-cycle `start_i` pulse loads the ratio. The block picks one of three stepping schemes: shrink, whole-number enlarge or fractional enlarge. It then hands entries out on a valid/ready stream. The divisions and the modulo that the stepping needs share one iterative divider, so the stream idles between entries while the divider works. Ratios the table cannot hold raise an error flag. A 1:1 ratio produces no entries and raises a flag that says this axis needs no resizing.

Top module: `rsz_phase_table`

## Requirements
- R1: The down flag on every entry is 1 when denom > num and 0 otherwise. Whole-number enlarge applies when denom == 1, and fractional enlarge covers every other accepted ratio.
- R2: An accepted ratio other than 1:1 yields exactly num entries. The first flag is set on entry 0 only, and `busy_o` is low again after the last entry has been accepted.
- R3: In fractional enlarge an accumulator starts at 0. Entry i has weight 512 − floor(512·acc/num). The accumulator then gains denom. If it has reached num, the entry's advance is 1 and num is taken off the accumulator; otherwise the advance is 0.
- R4: In whole-number enlarge every entry has weight 512. The advance is 0 on every entry except the last, where it is 1.
- R5: In shrink mode the accumulator starts at denom. For each entry it is first set to num + ((acc − num) mod 2·num), and the weight is 512 − floor(512·(acc − num)/(2·num)). The accumulator then gains 2·denom, and the advance is floor((acc − num)/(2·num)).
- R6: A ratio with num > 31, num == 0 or denom == 0 sets `err_o` in the cycle after the start pulse, produces no entries and leaves `busy_o` low. `err_o` holds until the next start.
- R7: A 1:1 ratio sets `bypass_o` in the cycle after the start pulse, produces no entries and leaves `busy_o` low. `bypass_o` holds until the next start.
- R8: While `ent_valid_o` is high and `ent_ready_i` is low, the valid signal and every entry field hold their values into the next cycle.
- R9: In reset and straight after it, `busy_o`, `ent_valid_o`, `err_o` and `bypass_o` are low.
- R10: A start pulse while `busy_o` is high is ignored. The table in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that loads a ratio |
| num_i | input | NUM_W | Ratio numerator (output phases) |
| den_i | input | DEN_W | Ratio denominator (source pixels) |
| busy_o | output | 1 | Table generation in progress |
| err_o | output | 1 | Last ratio rejected |
| bypass_o | output | 1 | Last ratio was 1:1; axis not resized |
| ent_valid_o | output | 1 | Entry available |
| ent_ready_i | input | 1 | Consumer takes the entry |
| ent_wgt_o | output | WGT_W | Bilinear weight, 512 = all of the nearer pixel |
| ent_ofs_o | output | DEN_W | Source pixels to advance after this phase |
| ent_first_o | output | 1 | Marks entry 0 |
| ent_down_o | output | 1 | Table built for a shrinking ratio |

## Verification
The ratios 3:2, 7:2 and 31:30 drive the fractional accumulator. 31:30 also tests the largest table, whose advance is 1 on every entry but one. The ratios 4:1 and 2:1 separate the whole-number path from the fractional one. The shrink ratios 2:3, 5:7, 1:4 and 30:31 exercise the modulo seeding, multi-pixel advances and a table of a single entry. Uneven ready patterns confirm that entries hold while stalled. The ratios 32:5, 0:3 and 1:1 show the error and bypass outcomes, and a start pulse sent during a run shows that it is ignored.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
  typedef enum logic [1:0] {
    MODE_DOWN = 2'd0,
    MODE_INT  = 2'd1,
    MODE_FRAC = 2'd2
  } rsz_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_WGT  = 3'd2,
    ST_OFS  = 3'd3,
    ST_EMIT = 3'd4
  } rsz_state_e;
endpackage

// File: rtl/rsz_mode_decode.sv
module rsz_mode_decode
  import rsz_pkg::*;
#(
  parameter int NUM_W   = 6,
  parameter int DEN_W   = 8,
  parameter int MAX_ENT = 31
) (
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output rsz_mode_e        mode_o,
  output logic             bad_o,
  output logic             unity_o
);
  localparam int CMP_W = (NUM_W > DEN_W) ? NUM_W : DEN_W;

  logic [CMP_W-1:0] num_x, den_x;
  assign num_x = CMP_W'(num_i);
  assign den_x = CMP_W'(den_i);

  always_comb begin
    bad_o   = (num_x == '0) || (den_x == '0) || (num_x > CMP_W'(MAX_ENT));
    unity_o = (num_x == CMP_W'(1)) && (den_x == CMP_W'(1));
    if (den_x > num_x)             mode_o = MODE_DOWN;
    else if (den_x == CMP_W'(1))   mode_o = MODE_INT;
    else                           mode_o = MODE_FRAC;
  end
endmodule

// File: rtl/rsz_divider.sv
module rsz_divider #(
  parameter int DVD_W = 16,
  parameter int DVS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [DVD_W-1:0] dvd_i,
  input  logic [DVS_W-1:0] dvs_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] quo_o,
  output logic [DVS_W-1:0] rem_o
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [DVD_W-1:0] quo_q, quo_n;
  logic [DVS_W-1:0] rem_q, rem_n, dvs_q, dvs_n;
  logic             done_q, done_n;
  logic [DVS_W:0]   trial;

  assign trial = {rem_q, quo_q[DVD_W-1]};

  always_comb begin
    cnt_n  = cnt_q;
    quo_n  = quo_q;
    rem_n  = rem_q;
    dvs_n  = dvs_q;
    done_n = 1'b0;
    if (go_i) begin
      cnt_n = CNT_W'(DVD_W);
      quo_n = dvd_i;
      rem_n = '0;
      dvs_n = dvs_i;
    end else if (cnt_q != '0) begin
      if (trial >= {1'b0, dvs_q}) begin
        rem_n = DVS_W'(trial - {1'b0, dvs_q});
        quo_n = {quo_q[DVD_W-2:0], 1'b1};
      end else begin
        rem_n = trial[DVS_W-1:0];
        quo_n = {quo_q[DVD_W-2:0], 1'b0};
      end
      cnt_n  = cnt_q - CNT_W'(1);
      done_n = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      quo_q  <= quo_n;
      rem_q  <= rem_n;
      dvs_q  <= dvs_n;
      done_q <= done_n;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

  // The divisor must be non-zero for every division the schemes of R3 and R5 start
  p_div_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (dvs_i != '0));
  // A new division only starts once the previous one has finished
  p_div_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !busy_o);
endmodule

// File: rtl/rsz_phase_seq.sv
module rsz_phase_seq
  import rsz_pkg::*;
#(
  parameter int NUM_W = 6,
  parameter int DEN_W = 8,
  parameter int WGT_W = 10,
  parameter int DVD_W = 16,
  parameter int DVS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  input  rsz_mode_e        mode_i,
  input  logic             bad_i,
  input  logic             unity_i,
  output logic             dv_go_o,
  output logic [DVD_W-1:0] dv_dvd_o,
  output logic [DVS_W-1:0] dv_dvs_o,
  input  logic             dv_done_i,
  input  logic [DVD_W-1:0] dv_quo_i,
  input  logic [DVS_W-1:0] dv_rem_i,
  output logic             busy_o,
  output logic             err_o,
  output logic             bypass_o,
  output logic             ent_valid_o,
  input  logic             ent_ready_i,
  output logic [WGT_W-1:0] ent_wgt_o,
  output logic [DEN_W-1:0] ent_ofs_o,
  output logic             ent_first_o,
  output logic             ent_down_o
);
  localparam logic [WGT_W-1:0] FULL = WGT_W'(1) << (WGT_W - 1);
  localparam int SUM_W = ((DEN_W > DVS_W) ? DEN_W : DVS_W) + 1;

  rsz_state_e       st_q, st_n;
  rsz_mode_e        mode_q, mode_n;
  logic [NUM_W-1:0] num_q, num_n, idx_q, idx_n;
  logic [DEN_W-1:0] den_q, den_n, ofs_q, ofs_n;
  logic [DVS_W-1:0] acc_q, acc_n;
  logic [WGT_W-1:0] wgt_q, wgt_n;
  logic             err_q, err_n, byp_q, byp_n;
  logic [SUM_W-1:0] fsum;
  logic [DVS_W-1:0] two_num;
  logic             last_ent;

  assign fsum     = SUM_W'(acc_q) + SUM_W'(den_q);
  assign two_num  = {num_q[DVS_W-2:0], 1'b0};
  assign last_ent = (idx_q == num_q - NUM_W'(1));

  always_comb begin
    st_n     = st_q;
    mode_n   = mode_q;
    num_n    = num_q;
    den_n    = den_q;
    idx_n    = idx_q;
    acc_n    = acc_q;
    wgt_n    = wgt_q;
    ofs_n    = ofs_q;
    err_n    = err_q;
    byp_n    = byp_q;
    dv_go_o  = 1'b0;
    dv_dvd_o = '0;
    dv_dvs_o = '0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        num_n  = num_i;
        den_n  = den_i;
        idx_n  = '0;
        mode_n = mode_i;
        err_n  = bad_i;
        byp_n  = unity_i && !bad_i;
        if (!bad_i && !unity_i) begin
          case (mode_i)
            MODE_DOWN: begin
              dv_go_o  = 1'b1;
              dv_dvd_o = DVD_W'(den_i) - DVD_W'(num_i);
              dv_dvs_o = {num_i[DVS_W-2:0], 1'b0};
              st_n     = ST_PRE;
            end
            MODE_INT: begin
              wgt_n = FULL;
              ofs_n = '0;
              st_n  = ST_EMIT;
            end
            default: begin
              acc_n    = '0;
              dv_go_o  = 1'b1;
              dv_dvd_o = '0;
              dv_dvs_o = DVS_W'(num_i);
              st_n     = ST_WGT;
            end
          endcase
        end
      end
      ST_PRE: if (dv_done_i) begin
        acc_n    = dv_rem_i;
        dv_go_o  = 1'b1;
        dv_dvd_o = DVD_W'(dv_rem_i) << (WGT_W - 1);
        dv_dvs_o = two_num;
        st_n     = ST_WGT;
      end
      ST_WGT: if (dv_done_i) begin
        wgt_n = FULL - dv_quo_i[WGT_W-1:0];
        if (mode_q == MODE_DOWN) begin
          dv_go_o  = 1'b1;
          dv_dvd_o = DVD_W'(acc_q) + (DVD_W'(den_q) << 1);
          dv_dvs_o = two_num;
          st_n     = ST_OFS;
        end else begin
          if (fsum >= SUM_W'(num_q)) begin
            ofs_n = DEN_W'(1);
            acc_n = DVS_W'(fsum - SUM_W'(num_q));
          end else begin
            ofs_n = '0;
            acc_n = DVS_W'(fsum);
          end
          st_n = ST_EMIT;
        end
      end
      ST_OFS: if (dv_done_i) begin
        ofs_n = dv_quo_i[DEN_W-1:0];
        acc_n = dv_rem_i;
        st_n  = ST_EMIT;
      end
      ST_EMIT: if (ent_ready_i) begin
        if (last_ent) begin
          st_n = ST_IDLE;
        end else begin
          idx_n = idx_q + NUM_W'(1);
          case (mode_q)
            MODE_INT: ofs_n = DEN_W'((idx_q + NUM_W'(2)) == num_q);
            MODE_DOWN: begin
              dv_go_o  = 1'b1;
              dv_dvd_o = DVD_W'(acc_q) << (WGT_W - 1);
              dv_dvs_o = two_num;
              st_n     = ST_WGT;
            end
            default: begin
              dv_go_o  = 1'b1;
              dv_dvd_o = DVD_W'(acc_q) << (WGT_W - 1);
              dv_dvs_o = DVS_W'(num_q);
              st_n     = ST_WGT;
            end
          endcase
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_FRAC;
      num_q  <= '0;
      den_q  <= '0;
      idx_q  <= '0;
      acc_q  <= '0;
      wgt_q  <= '0;
      ofs_q  <= '0;
      err_q  <= 1'b0;
      byp_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      mode_q <= mode_n;
      num_q  <= num_n;
      den_q  <= den_n;
      idx_q  <= idx_n;
      acc_q  <= acc_n;
      wgt_q  <= wgt_n;
      ofs_q  <= ofs_n;
      err_q  <= err_n;
      byp_q  <= byp_n;
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign err_o       = err_q;
  assign bypass_o    = byp_q;
  assign ent_valid_o = (st_q == ST_EMIT);
  assign ent_wgt_o   = wgt_q;
  assign ent_ofs_o   = ofs_q;
  assign ent_first_o = (idx_q == '0);
  assign ent_down_o  = (mode_q == MODE_DOWN);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid_o && !ent_ready_i |=> ent_valid_o && $stable(ent_wgt_o)
      && $stable(ent_ofs_o) && $stable(ent_first_o) && $stable(ent_down_o));
  p_wgt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dv_done_i && (st_q == ST_WGT) |-> (dv_quo_i < DVD_W'(FULL)));
  p_ofs_fit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dv_done_i && (st_q == ST_OFS) |-> (dv_quo_i < (DVD_W'(1) << DEN_W)));
  p_int_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid_o && (mode_q == MODE_INT) |-> (ent_wgt_o == FULL));
  p_frac_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid_o && (mode_q == MODE_FRAC) |-> (ent_ofs_o <= DEN_W'(1)));
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !ent_valid_o && !bypass_o);
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(num_q) && $stable(den_q) && $stable(mode_q));
endmodule

// File: rtl/rsz_phase_table.sv
module rsz_phase_table
  import rsz_pkg::*;
#(
  parameter int NUM_W   = 6,
  parameter int DEN_W   = 8,
  parameter int WGT_W   = 10,
  parameter int MAX_ENT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             err_o,
  output logic             bypass_o,
  output logic             ent_valid_o,
  input  logic             ent_ready_i,
  output logic [WGT_W-1:0] ent_wgt_o,
  output logic [DEN_W-1:0] ent_ofs_o,
  output logic             ent_first_o,
  output logic             ent_down_o
);
  localparam int DVS_W  = NUM_W + 1;
  localparam int DVD_A  = WGT_W - 1 + DVS_W;
  localparam int DVD_B  = DEN_W + 2;
  localparam int DVD_W  = (DVD_A > DVD_B) ? DVD_A : DVD_B;

  logic             rst_s1, rst_sn;
  rsz_mode_e        dec_mode;
  logic             dec_bad, dec_unity;
  logic             dv_go, dv_busy, dv_done;
  logic [DVD_W-1:0] dv_dvd, dv_quo;
  logic [DVS_W-1:0] dv_dvs, dv_rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  rsz_mode_decode #(.NUM_W(NUM_W), .DEN_W(DEN_W), .MAX_ENT(MAX_ENT)) dec_i (
    .num_i(num_i), .den_i(den_i),
    .mode_o(dec_mode), .bad_o(dec_bad), .unity_o(dec_unity)
  );

  rsz_divider #(.DVD_W(DVD_W), .DVS_W(DVS_W)) div_i (
    .clk(clk), .rst_n(rst_sn), .go_i(dv_go), .dvd_i(dv_dvd), .dvs_i(dv_dvs),
    .busy_o(dv_busy), .done_o(dv_done), .quo_o(dv_quo), .rem_o(dv_rem)
  );

  rsz_phase_seq #(.NUM_W(NUM_W), .DEN_W(DEN_W), .WGT_W(WGT_W),
                  .DVD_W(DVD_W), .DVS_W(DVS_W)) seq_i (
    .clk(clk), .rst_n(rst_sn), .start_i(start_i), .num_i(num_i), .den_i(den_i),
    .mode_i(dec_mode), .bad_i(dec_bad), .unity_i(dec_unity),
    .dv_go_o(dv_go), .dv_dvd_o(dv_dvd), .dv_dvs_o(dv_dvs),
    .dv_done_i(dv_done), .dv_quo_i(dv_quo), .dv_rem_i(dv_rem),
    .busy_o(busy_o), .err_o(err_o), .bypass_o(bypass_o),
    .ent_valid_o(ent_valid_o), .ent_ready_i(ent_ready_i),
    .ent_wgt_o(ent_wgt_o), .ent_ofs_o(ent_ofs_o),
    .ent_first_o(ent_first_o), .ent_down_o(ent_down_o)
  );

  // An entry is only offered while the divider sits idle, as R2 expects
  p_emit_div_idle_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    ent_valid_o |-> !dv_busy);
  // R9: nothing leaves the block while the synchronised reset is held
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_sn |-> !busy_o && !ent_valid_o && !err_o && !bypass_o);
endmodule

// File: tb/rsz_phase_table_tb_top.sv
`timescale 1ns/1ps
module rsz_phase_table_tb_top;
  localparam int NUM_W = 6;
  localparam int DEN_W = 8;
  localparam int WGT_W = 10;
  localparam int NV    = 12;

  // vector table: num, den, expected err, expected bypass, expected down flag, ready seed
  localparam int V_NUM  [NV] = '{3, 2, 4, 5, 31, 1, 30, 7, 2, 1, 32, 0};
  localparam int V_DEN  [NV] = '{2, 3, 1, 7, 30, 4, 31, 2, 1, 1, 5, 3};
  localparam int V_ERR  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam int V_BYP  [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam int V_DOWN [NV] = '{0, 1, 0, 1, 0, 1, 1, 0, 0, 0, 0, 0};
  localparam int V_SEED [NV] = '{0, 3, 2, 7, 0, 4, 3, 6, 2, 0, 0, 0};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [NUM_W-1:0] num_i = '0;
  logic [DEN_W-1:0] den_i = '0;
  logic             ent_ready_i = 1'b0;
  logic             busy_o, err_o, bypass_o, ent_valid_o, ent_first_o, ent_down_o;
  logic [WGT_W-1:0] ent_wgt_o;
  logic [DEN_W-1:0] ent_ofs_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  rsz_phase_table #(.NUM_W(NUM_W), .DEN_W(DEN_W), .WGT_W(WGT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .num_i(num_i), .den_i(den_i),
    .busy_o(busy_o), .err_o(err_o), .bypass_o(bypass_o),
    .ent_valid_o(ent_valid_o), .ent_ready_i(ent_ready_i),
    .ent_wgt_o(ent_wgt_o), .ent_ofs_o(ent_ofs_o),
    .ent_first_o(ent_first_o), .ent_down_o(ent_down_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_ratio(input int n, input int d, input int e_err, input int e_byp,
                           input int e_down, input int seed, input bit poke);
    int ew[32];
    int eo[32];
    int acc, got, cyc, exp_n;
    bit stalled;
    logic [WGT_W-1:0] s_w;
    logic [DEN_W-1:0] s_o;
    string tag;
    exp_n = (e_err != 0 || e_byp != 0) ? 0 : n;
    tag = (e_down != 0) ? "R5" : ((d == 1) ? "R4" : "R3");
    if (exp_n > 0) begin
      if (e_down != 0) begin
        acc = d;
        for (int i = 0; i < n; i++) begin
          acc = n + (acc - n) % (2 * n);
          ew[i] = 512 - 512 * (acc - n) / (2 * n);
          acc = acc + 2 * d;
          eo[i] = (acc - n) / (2 * n);
        end
      end else if (d == 1) begin
        for (int i = 0; i < n; i++) begin
          ew[i] = 512;
          eo[i] = (i == n - 1) ? 1 : 0;
        end
      end else begin
        acc = 0;
        for (int i = 0; i < n; i++) begin
          ew[i] = 512 - 512 * acc / n;
          acc = acc + d;
          eo[i] = (acc >= n) ? 1 : 0;
          if (acc >= n) acc = acc - n;
        end
      end
    end
    @(negedge clk);
    num_i = NUM_W'(n);
    den_i = DEN_W'(d);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == e_err[0], "R6 err flag", err_o, e_err);
    chk(bypass_o == e_byp[0], "R7 bypass flag", bypass_o, e_byp);
    if (exp_n == 0) chk(!busy_o, "R6/R7 busy stays low", busy_o, 0);
    got = 0;
    cyc = 0;
    stalled = 1'b0;
    s_w = '0;
    s_o = '0;
    while (busy_o && cyc < 5000) begin
      ent_ready_i = ((cyc * seed + 1) % 5) != 0;
      if (poke && cyc == 6) begin
        num_i = NUM_W'(7);
        den_i = DEN_W'(9);
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      if (stalled) begin
        chk(ent_valid_o && ent_wgt_o == s_w && ent_ofs_o == s_o, "R8 hold while stalled",
            {ent_valid_o, ent_wgt_o, ent_ofs_o}, {1'b1, s_w, s_o});
      end
      stalled = 1'b0;
      if (ent_valid_o) begin
        if (ent_ready_i) begin
          if (got < exp_n) begin
            chk(ent_wgt_o == WGT_W'(ew[got]) && ent_ofs_o == DEN_W'(eo[got]), tag,
                {ent_wgt_o, ent_ofs_o}, {WGT_W'(ew[got]), DEN_W'(eo[got])});
            chk(ent_first_o == (got == 0), "R2 first flag", ent_first_o, (got == 0));
            chk(ent_down_o == e_down[0], "R1 down flag", ent_down_o, e_down);
          end
          got++;
        end else begin
          stalled = 1'b1;
          s_w = ent_wgt_o;
          s_o = ent_ofs_o;
        end
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(got == exp_n, poke ? "R10 table count after ignored start" : "R2 entry count",
        got, exp_n);
    chk(!busy_o && !ent_valid_o, "R2 idle after table", {busy_o, ent_valid_o}, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !ent_valid_o && !err_o && !bypass_o, "R9 state in reset",
        {busy_o, ent_valid_o, err_o, bypass_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !ent_valid_o && !err_o && !bypass_o, "R9 state after reset",
        {busy_o, ent_valid_o, err_o, bypass_o}, 0);

    for (int v = 0; v < NV; v++) begin
      run_ratio(V_NUM[v], V_DEN[v], V_ERR[v], V_BYP[v], V_DOWN[v], V_SEED[v], 1'b0);
    end

    // R10: a start pulse in the middle of a 3:2 table must not disturb it
    run_ratio(3, 2, 0, 0, 0, 3, 1'b1);
    // R6 then R7 back to back: flags follow the most recent start
    run_ratio(33, 2, 1, 0, 0, 0, 1'b0);
    run_ratio(1, 1, 0, 1, 0, 0, 1'b0);
    chk(!err_o, "R6 err cleared by next start", err_o, 0);
    // whole-number and shrink again after the flags, with heavy back-pressure
    run_ratio(3, 1, 0, 0, 0, 1, 1'b0);
    run_ratio(3, 8, 0, 0, 1, 1, 1'b0);

    done_flag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule